// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host reach a small bank of byte-wide registers over a four-wire serial link made up of a chip select, a serial clock, a data-in line and a data-out line. Every transaction opens with an address byte. Its upper seven bits must equal the block's chip address, and its lowest bit selects the direction. A write then carries a pointer byte and any number of data bytes. A read streams register contents back to the host, starting at the pointer that the last write left behind. Bit 7 of the pointer byte turns on auto-increment, so one transaction can cover a run of consecutive registers.

The serial pins are sampled by the system clock through synchronizers. The block works in clock-idle-low mode: data in is taken on the rising serial clock edge, and data out changes on the falling edge. The data-out pin comes with an enable so that an external pad can float the line. The enable is raised only while the block is shifting out read data. Logic beside the block reads the register bank through a combinational parallel port.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, every register reads 0x00 and `miso_oe_o` is low.
- R2: The first byte of a transaction is taken MSB first on rising `sclk_i` edges. Bits 7:1 must equal CHIP_ADDR (default 7'b0010000). Bit 0 selects the direction: 0 means write, 1 means read.
- R3: In a write, the second byte sets the pointer. Its bit 7 is the auto-increment flag and bits 6:0 are the register address. Each later complete byte is stored in the addressed register.
- R4: With the flag set, the address advances by one after each data byte and wraps from 127 to 0. With the flag clear, every data byte goes to the same register.
- R5: A read returns register bytes MSB first, changing on falling `sclk_i` edges and starting at the pointer. Consecutive registers follow when the flag is set, and the same register repeats when it is clear. A read never changes the stored pointer.
- R6: The pointer and flag left by the last matching write, including any auto-increment advance, are the ones used by the next read.
- R7: `miso_oe_o` goes high only during the read data phase, from the first falling `sclk_i` edge after the direction bit. It stays low during writes and falls within 4 clocks of `cs_ni` going high.
- R8: When the chip address does not match, the rest of the transaction is ignored: no register changes and `miso_oe_o` stays low.
- R9: Raising `cs_ni` at any bit aborts the transaction and discards any partial byte. The next transaction starts again with the address byte.
- R10: Register addresses at or above NUM_REGS (default 16) drop writes and read back as 0x00.
- R11: `par_data_o` shows the register selected by `par_addr_i` combinationally, or 0x00 for an address that has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the data-to-host pad |
| par_addr_i | input | 7 | Parallel port register address |
| par_data_o | output | 8 | Parallel port register contents |

## Verification
A stale or corrupted pointer shows up in the first read byte of the next transaction, and the bench compares that byte with its behavioural model. A bit counter that is out of step shifts every later byte by one position, so the very next register write lands with the wrong value on the parallel port. An enable left high, or a register changed by an ignored transaction, is caught within a few clocks of chip select rising, because the bench compares the enable and a sweeping parallel-port read against the model on every clock while the link is idle.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHIP,
    ST_MAP,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } spi_state_e;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_reg_rx.sv
module spi_reg_rx #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (!active_i) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (rise_i) begin
      shift_q <= {shift_q[BYTE_W-3:0], sdi_i};
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_cnt_o    = cnt_q;
  assign byte_valid_o = active_i && rise_i && (cnt_q == LAST);
  assign byte_o       = {shift_q, sdi_i};

  // R9: a deselected link always restarts at bit zero
  a_r9_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_reg_tx.sv
module spi_reg_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              sdo_o
);
  logic [BYTE_W-1:0] shreg_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else if (!active_i) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else if (load_i) begin
      sdo_q   <= data_i[BYTE_W-1];
      shreg_q <= {data_i[BYTE_W-2:0], 1'b0};
    end else if (shift_i) begin
      sdo_q   <= shreg_q[BYTE_W-1];
      shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] par_addr_i,
  output logic [BYTE_W-1:0] par_data_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W:0] NUM_L = (ADDR_W+1)'(NUM_REGS);

  logic [BYTE_W-1:0] reg_vals [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(i))) q <= wr_data_i;
    end
    assign reg_vals[i] = q;
  end

  function automatic logic [BYTE_W-1:0] pick(input logic [ADDR_W-1:0] a);
    if ({1'b0, a} < NUM_L) return reg_vals[a[IDX_W-1:0]];
    return '0;
  endfunction

  assign rd_data_o  = pick(rd_addr_i);
  assign par_data_o = pick(par_addr_i);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ADDR = 7'b0010000,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [ADDR_W-1:0] par_addr_i,
  output logic [BYTE_W-1:0] par_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, mosi_s, sclk_d;
  logic              active, rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_valid;
  logic [BYTE_W-1:0] rx_byte;
  spi_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q, rd_addr_q;
  logic              inc_q, oe_q;
  logic              wr_en, tx_load, tx_shift;
  logic [BYTE_W-1:0] rd_data;

  spi_reg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  assign active = !cs_s;
  assign rise   = sclk_s && !sclk_d;
  assign fall   = !sclk_s && sclk_d;

  spi_reg_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .rise_i      (rise),
    .sdi_i       (mosi_s),
    .bit_cnt_o   (bit_cnt),
    .byte_valid_o(byte_valid),
    .byte_o      (rx_byte)
  );

  assign wr_en    = byte_valid && (state_q == ST_WDATA);
  assign tx_load  = active && fall && (state_q == ST_RDATA) && (bit_cnt == '0);
  assign tx_shift = active && fall && (state_q == ST_RDATA) && (bit_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      inc_q     <= 1'b0;
      rd_addr_q <= '0;
      oe_q      <= 1'b0;
    end else if (!active) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_q <= ST_CHIP;
        ST_CHIP: if (byte_valid) begin
          if (rx_byte[BYTE_W-1:1] != CHIP_ADDR) begin
            state_q <= ST_IGNORE;
          end else if (rx_byte[0]) begin
            state_q   <= ST_RDATA;
            rd_addr_q <= ptr_q;
          end else begin
            state_q <= ST_MAP;
          end
        end
        ST_MAP: if (byte_valid) begin
          ptr_q   <= rx_byte[ADDR_W-1:0];
          inc_q   <= rx_byte[BYTE_W-1];
          state_q <= ST_WDATA;
        end
        ST_WDATA: if (wr_en && inc_q) ptr_q <= ptr_q + 1'b1;
        ST_RDATA: if (tx_load) begin
          oe_q <= 1'b1;
          if (inc_q) rd_addr_q <= rd_addr_q + 1'b1;
        end
        ST_IGNORE: state_q <= ST_IGNORE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_reg_file #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (ptr_q),
    .wr_data_i (rx_byte),
    .rd_addr_i (rd_addr_q),
    .rd_data_o (rd_data),
    .par_addr_i(par_addr_i),
    .par_data_o(par_data_o)
  );

  spi_reg_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .load_i  (tx_load),
    .shift_i (tx_shift),
    .data_i  (rd_data),
    .sdo_o   (miso_o)
  );

  assign miso_oe_o = oe_q;

  // R7: enable only inside the read phase, dropped once deselected
  a_r7_oe_only_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> (state_q == ST_RDATA));
  a_r7_oe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !miso_oe_o);
  // R8: a foreign transaction stays ignored until deselect
  a_r8_ignore_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |=> (state_q == ST_IGNORE || state_q == ST_IDLE));
  // R4: pointer steps on incrementing writes, holds otherwise
  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && inc_q) |=> (ptr_q == $past(ptr_q) + 1'b1));
  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !inc_q) |=> $stable(ptr_q));
  // R5: reads leave the stored pointer alone
  a_r5_ptr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDATA) |=> $stable(ptr_q));
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF = 8;
  localparam int NUM_REGS = 16;
  localparam logic [6:0] CHIP = 7'b0010000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic [6:0] par_addr = '0;
  wire        miso, miso_oe;
  wire  [7:0] par_data;

  int n_checks = 0;
  int n_fail = 0;
  int cs_high_cnt = 0;
  bit sweep_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] m_rf [128];
  int m_ptr = 0;
  bit m_inc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .par_addr_i(par_addr), .par_data_o(par_data)
  );

  function automatic logic [7:0] mval(input int a);
    return (a < NUM_REGS) ? m_rf[a] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // idle-link monitor, compared against the model every clock
  always @(negedge clk) begin
    if (!rst_n || !cs_n) cs_high_cnt = 0;
    else cs_high_cnt++;
    if (cs_high_cnt >= 6) begin
      check("R7 idle enable", {31'b0, miso_oe}, 32'd0);
      if (sweep_en) begin
        check("R11 parallel sweep", {24'b0, par_data}, {24'b0, mval(int'(par_addr))});
        par_addr = par_addr + 1'b1;
      end
    end
  end

  task automatic check_reg(input int a, input logic [7:0] exp, input string req);
    sweep_en = 1'b0;
    @(negedge clk);
    par_addr = a[6:0];
    @(negedge clk);
    check(req, {24'b0, par_data}, {24'b0, exp});
    sweep_en = 1'b1;
  endtask

  task automatic xfer_start();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (SCK_HALF) @(negedge clk);
  endtask

  task automatic xfer_stop();
    repeat (SCK_HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*SCK_HALF) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx, output bit oe_all, output bit oe_any);
    rx = '0;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (SCK_HALF) @(negedge clk);
      rx[i] = miso;
      if (miso_oe !== 1'b1) oe_all = 1'b0;
      if (miso_oe !== 1'b0) oe_any = 1'b1;
      sclk = 1'b1;
      repeat (SCK_HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic do_write(input logic [6:0] chip, input logic [7:0] mapb,
                          input logic [7:0] data [$], input string req);
    logic [7:0] rx;
    bit oa, on;
    bit hit;
    hit = (chip == CHIP);
    xfer_start();
    shift_bits({chip, 1'b0}, 8, rx, oa, on);
    check({req, " R7 oe in addr byte"}, {31'b0, on}, 32'd0);
    shift_bits(mapb, 8, rx, oa, on);
    if (hit) begin
      m_ptr = int'(mapb[6:0]);
      m_inc = mapb[7];
    end
    foreach (data[k]) begin
      shift_bits(data[k], 8, rx, oa, on);
      check({req, " R7 oe in write"}, {31'b0, on}, 32'd0);
      if (hit) begin
        if (m_ptr < NUM_REGS) m_rf[m_ptr] = data[k];
        if (m_inc) m_ptr = (m_ptr + 1) % 128;
      end
    end
    xfer_stop();
  endtask

  task automatic do_read(input logic [6:0] chip, input int n, input string req);
    logic [7:0] rx;
    bit oa, on;
    int a;
    a = m_ptr;
    xfer_start();
    shift_bits({chip, 1'b1}, 8, rx, oa, on);
    for (int k = 0; k < n; k++) begin
      shift_bits(8'h00, 8, rx, oa, on);
      if (chip == CHIP) begin
        check(req, {24'b0, rx}, {24'b0, mval(a)});
        check({req, " R7 oe during read"}, {31'b0, oa}, 32'd1);
        if (m_inc) a = (a + 1) % 128;
      end else begin
        check({req, " R8 oe on foreign read"}, {31'b0, on}, 32'd0);
      end
    end
    xfer_stop();
  endtask

  initial begin
    logic [7:0] rx;
    bit oa, on;
    foreach (m_rf[i]) m_rf[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1 oe after reset", {31'b0, miso_oe}, 32'd0);
    for (int a = 0; a < NUM_REGS; a++) check_reg(a, 8'h00, "R1 reset value");

    // R2 R3: plain write
    do_write(CHIP, 8'h02, '{8'hA5}, "R3");
    check_reg(2, 8'hA5, "R2 R3 single write");

    // R4: incrementing burst, then fixed-address burst
    do_write(CHIP, 8'h84, '{8'h11, 8'h22, 8'h33}, "R4");
    check_reg(4, 8'h11, "R4 burst 0");
    check_reg(5, 8'h22, "R4 burst 1");
    check_reg(6, 8'h33, "R4 burst 2");
    do_write(CHIP, 8'h08, '{8'h44, 8'h55}, "R4");
    check_reg(8, 8'h55, "R4 fixed address last wins");
    check_reg(9, 8'h00, "R4 fixed address neighbour untouched");

    // R5: incrementing read, then repeat shows pointer unchanged
    do_write(CHIP, 8'h84, '{}, "R5 set pointer");
    do_read(CHIP, 3, "R5 incrementing read");
    do_read(CHIP, 1, "R5 pointer kept after read");

    // R6: pointer advanced by a write is used by the next read
    do_write(CHIP, 8'h0C, '{8'h77}, "R6");
    do_write(CHIP, 8'h8A, '{8'h01, 8'h02}, "R6");
    check_reg(10, 8'h01, "R6 burst 0");
    check_reg(11, 8'h02, "R6 burst 1");
    do_read(CHIP, 2, "R6 read after advancing write");

    // R5: non-incrementing read repeats one register
    do_write(CHIP, 8'h02, '{}, "R5 set pointer");
    do_read(CHIP, 2, "R5 fixed read");

    // R8: foreign chip address
    do_write(7'h11, 8'h00, '{8'hFF}, "R8");
    check_reg(0, 8'h00, "R8 foreign write ignored");
    do_read(7'h11, 2, "R8 foreign read");
    do_read(CHIP, 1, "R8 pointer untouched by foreign write");

    // R9: abort in the address byte, then a normal write
    xfer_start();
    shift_bits({CHIP, 1'b0}, 4, rx, oa, on);
    xfer_stop();
    do_write(CHIP, 8'h03, '{8'h5A}, "R9");
    check_reg(3, 8'h5A, "R9 write after aborted address byte");

    // R9: abort in a data byte leaves the register untouched
    xfer_start();
    shift_bits({CHIP, 1'b0}, 8, rx, oa, on);
    shift_bits(8'h0E, 8, rx, oa, on);
    m_ptr = 14;
    m_inc = 1'b0;
    shift_bits(8'hEE, 5, rx, oa, on);
    xfer_stop();
    check_reg(14, 8'h00, "R9 partial data byte discarded");

    // R10 R4: write beyond the bank wraps to 0
    do_write(CHIP, 8'hFF, '{8'h99, 8'h66}, "R10");
    check_reg(127, 8'h00, "R10 out-of-range write dropped");
    check_reg(0, 8'h66, "R4 R10 wrap to address 0");
    do_write(CHIP, 8'h20, '{}, "R10 set pointer");
    do_read(CHIP, 1, "R10 out-of-range read");

    // R11: sweep the parallel port against the model
    sweep_en = 1'b1;
    repeat (300) @(negedge clk);
    sweep_en = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule